// File: doc/BRIEF.md
# Four-Point Signature Detection Sequencer

This block runs one signature-detection cycle on a powered-device port. After a start request it asks the analog front end for two forced-current steps and records the port voltage each one produces. It then takes the slope between the two points (change in voltage over change in current), so a fixed offset from a series diode or from leakage drops out. If that slope lies in the valid window, it runs a second pair of steps in which the port voltage is forced and the resulting current is read. It applies the same slope test to that pair. A first reading too low to be a real device ends the cycle at once and reports a short. A second reading above a programmable ceiling reports an open port.

Force requests leave the block on a valid/ready stream. `frc_valid` stays high, and `frc_mode` and `frc_level` stay unchanged, until the front end takes the request with `frc_ready`. Readings arrive on a second valid/ready stream. The block raises `smp_ready` only while it waits for the reading that matches the request just accepted, so the front end may stall for any number of cycles. Start, done and the result code are plain pins.

Top module: `sigdet_seq`

## Requirements
- R1: After an accepted start, force requests are issued in this order: current `I_LO_UA`, current `I_HI_UA`, voltage `V_LO_MV`, voltage `V_HI_MV`. The mode encoding is 0 for forced current (µA) and 1 for forced voltage (mV). The cycle stops early wherever R2, R3 or R4 say so.
- R2: If the first reading (mV) is below `SHORT_MV` (1000), the cycle ends with code 1 (short) and issues no further request. A reading of exactly 1000 mV is not a short.
- R3: If the second reading is above `open_thr_mv`, the cycle ends with code 5 (open) after two requests. A reading equal to the threshold is not open.
- R4: For the current pair, 1000·ΔV is compared with 17000·ΔI and 29000·ΔI, where ΔI = I_HI−I_LO. Below the window gives code 2 (low), above it gives code 4 (high), and in both cases the voltage pair is skipped.
- R5: When the current pair is good, the voltage pair runs and the final code is its own classification: 2, 3 (good) or 4. A zero or negative current difference counts as high. The result is 3 only when both pairs are good.
- R6: Result codes are 0 unknown, 1 short, 2 low, 3 good, 4 high, 5 open. The result is 0 after reset and returns to 0 when a start is accepted.
- R7: A force request keeps its valid, mode and level unchanged until it is accepted.
- R8: A reading is taken only in a cycle with `smp_valid` and `smp_ready` both high. Readings offered at any other time have no effect, and `smp_ready` is never high while a force request is pending.
- R9: `done` is a single-cycle pulse in the cycle after the deciding reading or evaluation. The result then holds until the next accepted start, and a start during a running cycle is ignored.
- R10: Both window edges count as inside the window, and equal offsets on the two points of a pair do not change the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a detection cycle when idle |
| open_thr_mv | input | W | Open-circuit ceiling for the second reading, mV |
| frc_valid | output | 1 | Force request pending |
| frc_ready | input | 1 | Front end accepts the request |
| frc_mode | output | 1 | 0 forced current, 1 forced voltage |
| frc_level | output | W | Level in µA or mV |
| smp_valid | input | 1 | Reading present |
| smp_ready | output | 1 | Block waits for a reading |
| smp_data | input | W | Reading in mV or µA |
| done | output | 1 | One-cycle end-of-cycle pulse |
| result | output | 3 | Result code |

## Verification
The bound assertions check on every cycle that a pending request stays stable under stall and that the two streams are never open together. They also check that `done` lasts one cycle, that the result changes only at a done or a start, and that a finished cycle never reports unknown. Whether the slope arithmetic, the window edges, the early aborts and the method-disagreement rule produce the right code can only be shown by the bench's scenarios. In those, a behavioural model predicts every output on every cycle while the front end stalls, offers stray readings and repeats start.

// File: rtl/sigdet_pkg.sv
package sigdet_pkg;
  typedef enum logic [2:0] {
    RES_UNKNOWN = 3'd0,
    RES_SHORT   = 3'd1,
    RES_LOW     = 3'd2,
    RES_GOOD    = 3'd3,
    RES_HIGH    = 3'd4,
    RES_OPEN    = 3'd5
  } res_code_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_MEAS = 2'd2,
    ST_EVAL = 2'd3
  } seq_state_t;
endpackage

// File: rtl/sigdet_cls.sv
// Window classifier: slope R = 1000*dv/di ohm checked without a divider.
module sigdet_cls
  import sigdet_pkg::*;
#(
  parameter int W        = 16,
  parameter int RMIN_OHM = 17000,
  parameter int RMAX_OHM = 29000
) (
  input  logic signed [W:0] dv,
  input  logic signed [W:0] di,
  output res_code_t         code
);
  localparam int PW = 2 * W + 16;
  localparam logic signed [PW-1:0] K_SCALE = PW'(1000);
  localparam logic signed [PW-1:0] K_MIN   = PW'(RMIN_OHM);
  localparam logic signed [PW-1:0] K_MAX   = PW'(RMAX_OHM);

  logic signed [PW-1:0] dv_x, di_x, lhs, lo_b, hi_b;

  always_comb begin
    dv_x = PW'(dv);
    di_x = PW'(di);
    lhs  = dv_x * K_SCALE;
    lo_b = di_x * K_MIN;
    hi_b = di_x * K_MAX;
    if (di_x <= '0)      code = RES_HIGH;
    else if (lhs < lo_b) code = RES_LOW;
    else if (lhs > hi_b) code = RES_HIGH;
    else                 code = RES_GOOD;
  end
endmodule

// File: rtl/sigdet_ctrl.sv
// Step sequencer, capture registers and result/done registers.
module sigdet_ctrl
  import sigdet_pkg::*;
#(
  parameter int W        = 16,
  parameter int I_LO_UA  = 170,
  parameter int I_HI_UA  = 270,
  parameter int V_LO_MV  = 4000,
  parameter int V_HI_MV  = 8000,
  parameter int SHORT_MV = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     open_thr_mv,
  output logic             frc_valid,
  input  logic             frc_ready,
  output logic             frc_mode,
  output logic [W-1:0]     frc_level,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [W-1:0]     smp_data,
  output logic signed [W:0] cls_dv,
  output logic signed [W:0] cls_di,
  input  res_code_t        cls_code,
  output logic             done,
  output res_code_t        result
);
  localparam int NSTEP = 4;
  localparam int SW    = $clog2(NSTEP);
  localparam logic [W-1:0] SHORT_L = W'(SHORT_MV);
  localparam logic signed [W:0] DI_FORCED = (W+1)'(I_HI_UA - I_LO_UA);
  localparam logic signed [W:0] DV_FORCED = (W+1)'(V_HI_MV - V_LO_MV);

  seq_state_t        st;
  logic [SW-1:0]     step;
  logic [W-1:0]      samp [NSTEP];
  logic [W-1:0]      lvl_tab [NSTEP];

  // Step levels: two currents, then two voltages.
  assign lvl_tab[0] = W'(I_LO_UA);
  assign lvl_tab[1] = W'(I_HI_UA);
  assign lvl_tab[2] = W'(V_LO_MV);
  assign lvl_tab[3] = W'(V_HI_MV);

  assign frc_valid = (st == ST_CMD);
  assign frc_mode  = step[SW-1];
  assign frc_level = lvl_tab[step];
  assign smp_ready = (st == ST_MEAS);

  always_comb begin
    if (!step[SW-1]) begin
      cls_dv = $signed({1'b0, samp[1]}) - $signed({1'b0, samp[0]});
      cls_di = DI_FORCED;
    end else begin
      cls_dv = DV_FORCED;
      cls_di = $signed({1'b0, samp[3]}) - $signed({1'b0, samp[2]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      step   <= '0;
      done   <= 1'b0;
      result <= RES_UNKNOWN;
      for (int k = 0; k < NSTEP; k++) samp[k] <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          st     <= ST_CMD;
          step   <= '0;
          result <= RES_UNKNOWN;
        end
        ST_CMD: if (frc_ready) st <= ST_MEAS;
        ST_MEAS: if (smp_valid) begin
          samp[step] <= smp_data;
          case (step)
            2'd0: if (smp_data < SHORT_L) begin
                    result <= RES_SHORT; done <= 1'b1; st <= ST_IDLE;
                  end else begin
                    step <= 2'd1; st <= ST_CMD;
                  end
            2'd1: if (smp_data > open_thr_mv) begin
                    result <= RES_OPEN; done <= 1'b1; st <= ST_IDLE;
                  end else begin
                    st <= ST_EVAL;
                  end
            2'd2: begin step <= 2'd3; st <= ST_CMD; end
            default: st <= ST_EVAL;
          endcase
        end
        ST_EVAL: begin
          if (!step[SW-1] && cls_code == RES_GOOD) begin
            step <= 2'd2;
            st   <= ST_CMD;
          end else begin
            result <= cls_code;
            done   <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sigdet_seq.sv
module sigdet_seq
  import sigdet_pkg::*;
#(
  parameter int W        = 16,
  parameter int I_LO_UA  = 170,
  parameter int I_HI_UA  = 270,
  parameter int V_LO_MV  = 4000,
  parameter int V_HI_MV  = 8000,
  parameter int SHORT_MV = 1000,
  parameter int RMIN_OHM = 17000,
  parameter int RMAX_OHM = 29000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] open_thr_mv,
  output logic         frc_valid,
  input  logic         frc_ready,
  output logic         frc_mode,
  output logic [W-1:0] frc_level,
  input  logic         smp_valid,
  output logic         smp_ready,
  input  logic [W-1:0] smp_data,
  output logic         done,
  output logic [2:0]   result
);
  logic signed [W:0] dv_w, di_w;
  res_code_t         code_w, res_w;

  sigdet_ctrl #(
    .W(W), .I_LO_UA(I_LO_UA), .I_HI_UA(I_HI_UA),
    .V_LO_MV(V_LO_MV), .V_HI_MV(V_HI_MV), .SHORT_MV(SHORT_MV)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .open_thr_mv(open_thr_mv),
    .frc_valid(frc_valid), .frc_ready(frc_ready), .frc_mode(frc_mode),
    .frc_level(frc_level), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .cls_dv(dv_w), .cls_di(di_w), .cls_code(code_w),
    .done(done), .result(res_w)
  );

  sigdet_cls #(.W(W), .RMIN_OHM(RMIN_OHM), .RMAX_OHM(RMAX_OHM)) u_cls (
    .dv(dv_w), .di(di_w), .code(code_w)
  );

  assign result = res_w;
endmodule

// File: rtl/sigdet_chk.sv
module sigdet_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         frc_valid,
  input logic         frc_ready,
  input logic         frc_mode,
  input logic [W-1:0] frc_level,
  input logic         smp_ready,
  input logic         done,
  input logic [2:0]   result
);
  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (frc_valid && !frc_ready) |=> (frc_valid && $stable(frc_mode) && $stable(frc_level)));

  p_stream_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(frc_valid && smp_ready));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_res_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (result != $past(result)) |-> (done || $past(start)));

  p_done_code_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (result != 3'd0));

  p_code_range_r6: assert property (@(posedge clk) disable iff (rst)
    result <= 3'd5);
endmodule

bind sigdet_seq sigdet_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .frc_valid(frc_valid),
  .frc_ready(frc_ready), .frc_mode(frc_mode), .frc_level(frc_level),
  .smp_ready(smp_ready), .done(done), .result(result)
);

// File: tb/sigdet_seq_tb.sv
`timescale 1ns/1ps
module sigdet_seq_tb_top;
  localparam int W = 16;
  localparam int ILO = 170, IHI = 270, VLO = 4000, VHI = 8000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] open_thr_mv = 16'd20000;
  logic frc_valid, frc_ready, frc_mode, smp_valid, smp_ready, done;
  logic [W-1:0] frc_level, smp_data;
  logic [2:0] result;

  always #2 clk = ~clk;  // 250 MHz

  sigdet_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .open_thr_mv(open_thr_mv),
    .frc_valid(frc_valid), .frc_ready(frc_ready), .frc_mode(frc_mode),
    .frc_level(frc_level), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .done(done), .result(result)
  );

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cls_ref(input longint dv, input longint di);
    if (di <= 0) return 4;
    if (dv * 1000 < 17000 * di) return 2;
    if (dv * 1000 > 29000 * di) return 4;
    return 3;
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_ph = 0, m_step = 0, m_res = 0;
  bit m_done = 1'b0;
  int m_s [4];
  int lv [4] = '{ILO, IHI, VLO, VHI};

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_step = 0; m_res = 0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      case (m_ph)
        0: if (start) begin m_ph = 1; m_step = 0; m_res = 0; end
        1: if (frc_ready) m_ph = 2;
        2: if (smp_valid) begin
             m_s[m_step] = int'(smp_data);
             if (m_step == 0) begin
               if (m_s[0] < 1000) begin m_res = 1; m_done = 1'b1; m_ph = 0; end
               else begin m_step = 1; m_ph = 1; end
             end else if (m_step == 1) begin
               if (m_s[1] > int'(open_thr_mv)) begin m_res = 5; m_done = 1'b1; m_ph = 0; end
               else m_ph = 3;
             end else if (m_step == 2) begin m_step = 3; m_ph = 1; end
             else m_ph = 3;
           end
        default: begin
          if (m_step == 1) begin
            int c;
            c = cls_ref(m_s[1] - m_s[0], IHI - ILO);
            if (c == 3) begin m_step = 2; m_ph = 1; end
            else begin m_res = c; m_done = 1'b1; m_ph = 0; end
          end else begin
            m_res = cls_ref(VHI - VLO, m_s[3] - m_s[2]);
            m_done = 1'b1; m_ph = 0;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk(frc_valid == (m_ph == 1), "R7 frc_valid", frc_valid, m_ph == 1);
      if (m_ph == 1) begin
        chk(frc_mode == (m_step >= 2), "R1 frc_mode", frc_mode, m_step >= 2);
        chk(int'(frc_level) == lv[m_step], "R1 frc_level", frc_level, lv[m_step]);
      end
      chk(smp_ready == (m_ph == 2), "R8 smp_ready", smp_ready, m_ph == 2);
      chk(done == m_done, "R9 done", done, m_done);
      chk(int'(result) == m_res, "R6 result", result, m_res);
    end
  end

  // ---------------- front-end responder ----------------
  int sv [4];
  int gap = 0, wctr = 0, cur = 0, hs_tot = 0, done_tot = 0;
  bit junk_en = 1'b0;

  always @(posedge clk) begin
    if (done) done_tot++;
    if (frc_valid && frc_ready) begin
      cur = (frc_mode ? 2 : 0) + ((int'(frc_level) == IHI || int'(frc_level) == VHI) ? 1 : 0);
      hs_tot++;
    end
    if ((frc_valid && frc_ready) || (smp_ready && smp_valid)) wctr = 0;
    else if (frc_valid || smp_ready) wctr++;
  end

  always @(negedge clk) begin
    frc_ready = frc_valid && (wctr >= gap);
    if (smp_ready) begin
      smp_valid = (wctr >= gap);
      smp_data  = W'(sv[cur]);
    end else begin
      smp_valid = junk_en;
      smp_data  = '0;
    end
  end

  // One detection cycle; restarts start while busy to show it is ignored.
  task automatic run(input int a, input int b, input int c, input int d,
                     input int g, input bit junk, input int exp_res,
                     input int exp_hs, input string tag);
    int hs0, dn0, n;
    sv[0] = a; sv[1] = b; sv[2] = c; sv[3] = d;
    gap = g; junk_en = junk;
    hs0 = hs_tot; dn0 = done_tot;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(int'(result) == 0, "R6 cleared on start", result, 0);
    repeat (2) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done == 1'b1, {tag, " done seen"}, done, 1);
    chk(int'(result) == exp_res, tag, result, exp_res);
    chk(hs_tot - hs0 == exp_hs, {tag, " request count"}, hs_tot - hs0, exp_hs);
    repeat (4) @(negedge clk);
    chk(done_tot - dn0 == 1, "R9 single done", done_tot - dn0, 1);
    chk(int'(result) == exp_res, "R9 result held", result, exp_res);
    chk(!frc_valid && !smp_ready, "R9 idle after done", frc_valid, 0);
  endtask

  initial begin
    frc_ready = 1'b0; smp_valid = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    chk(int'(result) == 0 && !done && !frc_valid && !smp_ready, "R6 reset state", result, 0);
    rst = 1'b0; cmp_en = 1'b1;
    // 25k with 700 mV offset: both methods good
    run(4950, 7450, 132, 292, 0, 1'b0, 3, 4, "R5 good 25k");
    run(4950, 7450, 132, 292, 3, 1'b1, 3, 4, "R8 stalls and stray samples");
    run(999, 0, 0, 0, 1, 1'b1, 1, 1, "R2 short abort");
    run(1000, 3500, 132, 292, 0, 1'b0, 3, 4, "R2 1000mV not short");
    run(15000, 25000, 0, 0, 2, 1'b0, 5, 2, "R3 open");
    run(18000, 20000, 165, 365, 0, 1'b0, 3, 4, "R3 at threshold not open");
    run(2400, 3400, 0, 0, 0, 1'b0, 2, 2, "R4 low 10k");
    run(6650, 10150, 0, 0, 1, 1'b0, 4, 2, "R4 high 35k");
    run(5000, 3000, 0, 0, 0, 1'b0, 2, 2, "R4 negative slope low");
    run(3590, 5290, 194, 429, 0, 1'b0, 3, 4, "R10 edge 17k inside");
    run(5630, 8530, 113, 251, 0, 1'b0, 3, 4, "R10 edge 29k inside");
    run(3000, 4699, 0, 0, 0, 1'b0, 2, 2, "R10 just below 17k");
    run(3000, 5901, 0, 0, 0, 1'b0, 4, 2, "R10 just above 29k");
    run(4950, 7450, 132, 200, 0, 1'b0, 4, 4, "R5 disagree voltage high");
    run(4950, 7450, 132, 600, 1, 1'b0, 2, 4, "R5 disagree voltage low");
    run(4950, 7450, 300, 300, 0, 1'b0, 4, 4, "R5 zero current step high");
    run(1700, 4200, 132, 292, 0, 1'b0, 3, 4, "R10 offset cancels");
    run(4950, 7450, 132, 292, 5, 1'b1, 3, 4, "R7 long stall");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule